// File: doc/BRIEF.md
# Residue-Protected Pointer ALU

This block performs arithmetic on 64-bit pointers that carry a separable multi-residue code. The plain address sits in the low 39 bits of the word and stays directly readable. The 25 bits above it hold five 5-bit residues of that address, one for each modulus in the set {31, 29, 23, 19, 17}. A processor datapath hands the unit an opcode and either two encoded pointers or one pointer with a signed immediate. One clock later the unit returns a result word and an error flag.

The unit can encode a plain address, strip the code from a pointer, add two pointers, subtract one from another, and add an immediate to a pointer. Arithmetic runs on the address and, in parallel, on each residue modulo its own modulus. No operation ever decodes and re-encodes the whole word. Before the result is used, every encoded operand is checked: its residues are recomputed from its address bits and compared with the stored ones. A result that would leave the 39-bit address range is rejected rather than wrapped, because a wrapped address would no longer match residues computed modulo the small moduli. Whenever an error is raised, the result word is forced to zero.

Top module: `mrp_alu`

## Requirements
- R1: Word layout. The address is bits [38:0]. The residue modulo 31 is in [63:59], modulo 29 in [58:54], modulo 23 in [53:49], modulo 19 in [48:44] and modulo 17 in [43:39]. Opcodes are 0 encode, 1 decode, 2 add, 3 subtract and 4 add-immediate. Every error-free result of encode, add, subtract or add-immediate is a consistent code word.
- R2: `out_valid` rises exactly one cycle after `in_valid`. While `out_valid` is low, `res` and `err` are zero. Synchronous reset clears all outputs.
- R3: Encode takes `a` as a plain value. It returns `a[38:0]` with each residue equal to `a[38:0]` mod m. If any of `a[63:39]` is set, it flags an error.
- R4: Decode checks `a` and returns `a[38:0]` with bits [63:39] cleared.
- R5: Add returns address `a+b`. Each residue becomes (ra+rb) mod m.
- R6: Subtract returns address `a-b`. Each residue becomes (ra-rb) mod m.
- R7: Add-immediate sign-extends the 12-bit `imm`, adds it to the address of `a`, and updates each residue by the residue of the immediate.
- R8: Any encoded operand whose stored residues differ from residues recomputed from its address raises `err`. This covers `a` for decode, add, subtract and add-immediate, and `b` for add and subtract. `b` has no effect on encode, decode or add-immediate.
- R9: An arithmetic result at or above 2^39, or below zero, raises `err`.
- R10: Opcodes 5 to 7 raise `err`. On any error, `res` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| op | input | 3 | Opcode |
| a | input | 64 | First operand (plain value for encode) |
| b | input | 64 | Second encoded operand |
| imm | input | 12 | Signed immediate for add-immediate |
| out_valid | output | 1 | Result valid, one cycle after request |
| res | output | 64 | Result word |
| err | output | 1 | Operand check, range or opcode error |

## Verification
All results come from a single output register, so `res`, `err` and `out_valid` all appear at the first rising edge after a request is presented. The bench drives each request on a falling edge and reads the outputs at the next falling edge, half a cycle after the register has loaded. It then drops `in_valid` for at least one cycle, which lets idle outputs be checked as zero. Expected words come from a bench model that encodes addresses with plain modulo arithmetic and does not use residue lanes.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
  localparam int ADDR_W = 39;
  localparam int RES_W  = 5;
  localparam int NRES   = 5;
  localparam int IMM_W  = 12;

  typedef enum logic [2:0] {
    OP_ENC  = 3'd0,
    OP_DEC  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_ADDI = 3'd4
  } op_e;

  // lane 0 is the highest field of the word
  function automatic int lane_modulus(int j);
    case (j)
      0:       return 31;
      1:       return 29;
      2:       return 23;
      3:       return 19;
      default: return 17;
    endcase
  endfunction
endpackage

// File: rtl/mrp_residue_calc.sv
module mrp_residue_calc #(
  parameter int IN_W = 39,
  parameter int M    = 31,
  parameter int RW   = 5
) (
  input  logic [IN_W-1:0] val,
  output logic [RW-1:0]   rem
);
  localparam logic [IN_W-1:0] MV = IN_W'(M);
  assign rem = RW'(val % MV);
endmodule

// File: rtl/mrp_res_lane.sv
module mrp_res_lane #(
  parameter int M  = 31,
  parameter int RW = 5
) (
  input  logic [RW-1:0] ra,
  input  logic [RW-1:0] rb,
  input  logic          sub,
  output logic [RW-1:0] r
);
  localparam logic [RW:0] MV = (RW+1)'(M);
  logic [RW:0] s;

  always_comb begin
    if (sub) begin
      if (ra >= rb) s = {1'b0, ra} - {1'b0, rb};
      else          s = {1'b0, ra} + MV - {1'b0, rb};
    end else begin
      s = {1'b0, ra} + {1'b0, rb};
      if (s >= MV) s = s - MV;
    end
    r = RW'(s);
  end
endmodule

// File: rtl/mrp_operand_check.sv
module mrp_operand_check #(
  parameter int ADDR_W = 39,
  parameter int RW     = 5,
  parameter int NRES   = 5,
  parameter int WORD_W = ADDR_W + NRES * RW
) (
  input  logic [WORD_W-1:0] word,
  output logic [RW-1:0]     calc [NRES],
  output logic              ok
);
  logic [NRES-1:0] match;

  for (genvar j = 0; j < NRES; j++) begin : g_lane
    mrp_residue_calc #(
      .IN_W(ADDR_W), .M(mrp_pkg::lane_modulus(j)), .RW(RW)
    ) u_calc (
      .val(word[ADDR_W-1:0]),
      .rem(calc[j])
    );
    assign match[j] = (calc[j] == word[ADDR_W + (NRES-1-j)*RW +: RW]);
  end

  assign ok = &match;
endmodule

// File: rtl/mrp_alu.sv
module mrp_alu #(
  parameter int ADDR_W = mrp_pkg::ADDR_W,
  parameter int RES_W  = mrp_pkg::RES_W,
  parameter int NRES   = mrp_pkg::NRES,
  parameter int IMM_W  = mrp_pkg::IMM_W,
  parameter int WORD_W = ADDR_W + NRES * RES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [IMM_W-1:0]  imm,
  output logic              out_valid,
  output logic [WORD_W-1:0] res,
  output logic              err
);
  import mrp_pkg::*;

  localparam int EXT_W = ADDR_W + 2;
  localparam int HI_W  = WORD_W - ADDR_W;

  op_e              opc;
  logic [RES_W-1:0] calc_a [NRES];
  logic [RES_W-1:0] calc_b [NRES];
  logic [RES_W-1:0] rimm   [NRES];
  logic [RES_W-1:0] rlane  [NRES];
  logic             ok_a, ok_b;
  logic [IMM_W-1:0] imm_mag;
  logic [EXT_W-1:0] opnd, wide;
  logic             range_bad;
  logic [HI_W-1:0]  enc_hi, ari_hi;
  logic [WORD_W-1:0] res_d;
  logic             err_d;

  assign opc = op_e'(op);

  mrp_operand_check #(.ADDR_W(ADDR_W), .RW(RES_W), .NRES(NRES), .WORD_W(WORD_W))
    u_chk_a (.word(a), .calc(calc_a), .ok(ok_a));
  mrp_operand_check #(.ADDR_W(ADDR_W), .RW(RES_W), .NRES(NRES), .WORD_W(WORD_W))
    u_chk_b (.word(b), .calc(calc_b), .ok(ok_b));

  // magnitude of the immediate; -2^(IMM_W-1) maps onto itself, read unsigned
  assign imm_mag = imm[IMM_W-1] ? (~imm + 1'b1) : imm;

  for (genvar j = 0; j < NRES; j++) begin : g_lane
    localparam int M = lane_modulus(j);
    localparam int LO = (NRES-1-j) * RES_W;
    logic [RES_W-1:0] rmag, rb_sel;

    mrp_residue_calc #(.IN_W(IMM_W), .M(M), .RW(RES_W))
      u_imm (.val(imm_mag), .rem(rmag));

    assign rimm[j] = (imm[IMM_W-1] && rmag != '0) ? RES_W'(M) - rmag : rmag;
    assign rb_sel  = (opc == OP_ADDI) ? rimm[j] : b[ADDR_W + LO +: RES_W];

    mrp_res_lane #(.M(M), .RW(RES_W)) u_lane (
      .ra (a[ADDR_W + LO +: RES_W]),
      .rb (rb_sel),
      .sub(opc == OP_SUB),
      .r  (rlane[j])
    );

    assign enc_hi[LO +: RES_W] = calc_a[j];
    assign ari_hi[LO +: RES_W] = rlane[j];
  end

  always_comb begin
    if (opc == OP_ADDI) opnd = {{(EXT_W-IMM_W){imm[IMM_W-1]}}, imm};
    else                opnd = {2'b00, b[ADDR_W-1:0]};
    if (opc == OP_SUB)  wide = {2'b00, a[ADDR_W-1:0]} - opnd;
    else                wide = {2'b00, a[ADDR_W-1:0]} + opnd;
    range_bad = |wide[EXT_W-1:ADDR_W];
  end

  always_comb begin
    res_d = '0;
    err_d = 1'b0;
    case (opc)
      OP_ENC: begin
        err_d = |a[WORD_W-1:ADDR_W];
        res_d = {enc_hi, a[ADDR_W-1:0]};
      end
      OP_DEC: begin
        err_d = !ok_a;
        res_d = {{HI_W{1'b0}}, a[ADDR_W-1:0]};
      end
      OP_ADD, OP_SUB: begin
        err_d = !ok_a || !ok_b || range_bad;
        res_d = {ari_hi, wide[ADDR_W-1:0]};
      end
      OP_ADDI: begin
        err_d = !ok_a || range_bad;
        res_d = {ari_hi, wide[ADDR_W-1:0]};
      end
      default: err_d = 1'b1;
    endcase
    if (err_d) res_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid <= 1'b0;
      res       <= '0;
      err       <= 1'b0;
    end else begin
      out_valid <= 1'b1;
      res       <= res_d;
      err       <= err_d;
    end
  end
endmodule

// File: rtl/mrp_alu_chk.sv
module mrp_alu_chk #(
  parameter int ADDR_W = mrp_pkg::ADDR_W,
  parameter int RES_W  = mrp_pkg::RES_W,
  parameter int NRES   = mrp_pkg::NRES,
  parameter int WORD_W = ADDR_W + NRES * RES_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [WORD_W-1:0] a,
  input logic [WORD_W-1:0] b,
  input logic              out_valid,
  input logic [WORD_W-1:0] res,
  input logic              err
);
  logic code_ok;
  always_comb begin
    code_ok = 1'b1;
    for (int j = 0; j < NRES; j++) begin
      if (RES_W'(res[ADDR_W-1:0] % ADDR_W'(mrp_pkg::lane_modulus(j)))
          != res[ADDR_W + (NRES-1-j)*RES_W +: RES_W])
        code_ok = 1'b0;
    end
  end

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (res == '0 && !err));
  p_err_zero_r10: assert property (@(posedge clk) disable iff (rst)
    err |-> res == '0);
  p_code_ok_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !err && $past(op) != 3'd1) |-> code_ok);
  p_dec_strip_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !err && $past(op) == 3'd1) |->
      res == {{(WORD_W-ADDR_W){1'b0}}, $past(a[ADDR_W-1:0])});
  p_add_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !err && $past(op) == 3'd2) |->
      res[ADDR_W-1:0] == $past(a[ADDR_W-1:0]) + $past(b[ADDR_W-1:0]));
  p_bad_op_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op) > 3'd4) |-> err);
endmodule

bind mrp_alu mrp_alu_chk #(
  .ADDR_W(ADDR_W), .RES_W(RES_W), .NRES(NRES), .WORD_W(WORD_W)
) u_mrp_alu_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a), .b(b),
  .out_valid(out_valid), .res(res), .err(err)
);

// File: tb/tb_mrp_alu.sv
module tb_mrp_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic [11:0] imm = '0;
  logic        out_valid, err;
  logic [63:0] res;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  mrp_alu dut (.clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a),
               .b(b), .imm(imm), .out_valid(out_valid), .res(res), .err(err));

  function automatic logic [63:0] enc(logic [38:0] x);
    int mods [5] = '{31, 29, 23, 19, 17};
    logic [63:0] w = {25'b0, x};
    for (int j = 0; j < 5; j++)
      w[39 + (4-j)*5 +: 5] = 5'(longint'(x) % mods[j]);
    return w;
  endfunction

  function automatic logic [64:0] model(logic [2:0] o, logic [63:0] x,
                                        logic [63:0] y, logic [11:0] im);
    logic e = 1'b0;
    logic [63:0] r = '0;
    logic okx = (enc(x[38:0]) == x);
    logic oky = (enc(y[38:0]) == y);
    longint v;
    case (o)
      3'd0: begin e = (x[63:39] != 0); r = enc(x[38:0]); end
      3'd1: begin e = !okx; r = {25'b0, x[38:0]}; end
      3'd2, 3'd3, 3'd4: begin
        if (o == 3'd2)      v = longint'(x[38:0]) + longint'(y[38:0]);
        else if (o == 3'd3) v = longint'(x[38:0]) - longint'(y[38:0]);
        else                v = longint'(x[38:0]) + longint'($signed(im));
        e = !okx || (o != 3'd4 && !oky) || v < 0 || v >= (longint'(1) << 39);
        r = enc(39'(v));
      end
      default: e = 1'b1;
    endcase
    if (e) r = '0;
    return {e, r};
  endfunction

  task automatic check(string tag, logic [63:0] gr, logic ge,
                       logic [63:0] er, logic ee);
    total++;
    if (gr !== er || ge !== ee) begin
      bad++;
      $display("FAIL %s: got res=%h err=%b, expected res=%h err=%b",
               tag, gr, ge, er, ee);
    end
  endtask

  task automatic run(string tag, logic [2:0] o, logic [63:0] x,
                     logic [63:0] y, logic [11:0] im);
    logic [64:0] exp = model(o, x, y, im);
    @(negedge clk);
    op = o; a = x; b = y; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, res, err, exp[63:0], exp[64]);
    total++;
    if (out_valid !== 1'b1) begin
      bad++;
      $display("FAIL R2: out_valid=%b expected 1", out_valid);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] x, y;
    logic [38:0] ad, bd;
    logic [2:0]  o;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    check("R2 reset", res, err, 64'd0, 1'b0);
    rst = 1'b0;
    in_valid = 1'b0;

    run("R3 enc zero", 3'd0, 64'd0, 64'd0, 12'd0);
    run("R3 enc", 3'd0, 64'd12345, 64'd0, 12'd0);
    run("R1 enc max", 3'd0, {25'b0, {39{1'b1}}}, 64'd0, 12'd0);
    run("R3 R10 enc upper bit", 3'd0, 64'h0000_0080_0000_0001, 64'd0, 12'd0);
    run("R4 dec", 3'd1, enc(39'h12_3456_789A), 64'd0, 12'd0);
    run("R8 dec ignores b", 3'd1, enc(39'd77), enc(39'd5) ^ (64'd1 << 50), 12'd0);
    @(negedge clk);
    check("R2 idle", res, err, 64'd0, 1'b0);
    run("R5 add", 3'd2, enc(39'd1000), enc(39'd2345), 12'd0);
    run("R9 add overflow", 3'd2, enc({39{1'b1}}), enc(39'd1), 12'd0);
    run("R5 add top", 3'd2, enc({39{1'b1}} - 39'd4), enc(39'd4), 12'd0);
    run("R6 sub", 3'd3, enc(39'd500), enc(39'd123), 12'd0);
    run("R6 sub zero", 3'd3, enc(39'd31), enc(39'd31), 12'd0);
    run("R9 sub negative", 3'd3, enc(39'd3), enc(39'd4), 12'd0);
    run("R7 addi neg", 3'd4, enc(39'd100), enc(39'd0), 12'hFFB);
    run("R9 addi below zero", 3'd4, enc(39'd0), 64'd0, 12'hFFF);
    run("R7 addi min", 3'd4, enc(39'd5000), 64'd0, 12'h800);
    run("R7 addi max", 3'd4, enc(39'd1), 64'd0, 12'h7FF);
    run("R8 corrupt a", 3'd2, enc(39'd9) ^ (64'd1 << 63), enc(39'd1), 12'd0);
    run("R8 corrupt b", 3'd3, enc(39'd9), enc(39'd1) ^ (64'd1 << 39), 12'd0);
    run("R8 addi ignores b", 3'd4, enc(39'd9), 64'hFFFF_FFFF_FFFF_FFFF, 12'd3);
    run("R10 bad op", 3'd6, enc(39'd9), enc(39'd1), 12'd0);

    for (int i = 0; i < 400; i++) begin
      ad = 39'({$urandom, $urandom}) >> ($urandom % 39);
      bd = 39'({$urandom, $urandom}) >> ($urandom % 39);
      o  = ($urandom % 16 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
      x  = (o == 3'd0) ? {25'b0, ad} : enc(ad);
      y  = enc(bd);
      if ($urandom % 5 == 0) x[39 + $urandom % 25] ^= 1'b1;
      if ($urandom % 5 == 0) y[39 + $urandom % 25] ^= 1'b1;
      run("R1 R3 R4 R5 R6 R7 R8 R9 R10 random", o, x, y, 12'($urandom));
    end

    @(negedge clk);
    check("R2 final idle", res, err, 64'd0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule